// File: doc/BRIEF.md
# Home Write-Miss Invalidation Sequencer

This block is the home-side controller for a single directory entry in a tree-based coherence scheme. The entry holds four sharer pointers, each with a valid flag and a tree-height field. Each valid pointer names the root of one sharer tree. On a write miss, the controller sends invalidations only to those roots. The roots invalidate the nodes beneath them. The controller counts the acknowledgments it expects, and it grants exclusive ownership to the writer only after the last one has arrived. It also handles a request that finds an exclusive owner: it asks that owner for a writeback, waits, and then completes the read or the write.

The pointers are handled in pairs (0,1) and (2,3). The root under the odd slot of a pair gets its invalidation relayed through the root under the even slot. The even root acknowledges for the whole pair. As a result the home collects at most one acknowledgment per pair. The tree builder that serves read misses sits elsewhere. It fills the pointer array through a load port while the entry is stable and not exclusively owned. While the entry is in a transient state, every request gets a negative acknowledgment, and the requester retries.

Top module: `dir_home_wm_seq`

## Requirements
- R1: After reset the entry state code is 0 (uncached), all pointer valid flags are 0, and every output strobe is low.
- R2: The cycle after a write request to an entry with any valid pointer, the state code becomes 5 (invalidating). For each pair p (even slot 2p, odd slot 2p+1), `inv_valid[p]` pulses for one cycle, with this content:
  - If the even slot is valid, the target is the even pointer. In that case `relay_valid[p]` shows whether the odd slot is valid, and `relay_node` carries the odd pointer.
  - If only the odd slot is valid, the odd pointer is the target and there is no relay.
  - If neither slot is valid, no invalidation is sent for that pair.
- R3: While invalidating, the block expects one `ack_valid` per pair that got an invalidation. No grant appears before the last expected acknowledgment. The grant pulses in the cycle after that acknowledgment.
- R4: Every exclusive grant leaves the pointer array in this state: pointer slot 0 holds the writer and is the only valid slot, all levels are 0, the state code is 2 (exclusive), `grant_excl` is 1, and `grant_node` is the writer.
- R5: A write request to an uncached entry is granted exclusive in the next cycle, and no invalidation is sent.
- R6: A write request from another node to an exclusive entry pulses `wb_req_valid` to the owner in slot 0 and enters state 4. The next `wb_valid` grants exclusive to the writer.
- R7: A read request from another node to an exclusive entry pulses `wb_req_valid` to the owner and enters state 3. The next `wb_valid` grants shared (`grant_excl` 0) to the reader and leaves this directory state:
  - slot 0 holds the former owner and slot 1 holds the reader, and only those two slots are valid;
  - all levels are 0 and the state code is 1 (shared).
- R8: A request that arrives while the state is 3, 4 or 5 gets `nack_valid` with `nack_node` equal to the requester in the next cycle. This holds even in the cycle in which the pending operation completes, and that completion still grants to the original requester.
- R9: `ack_valid` outside state 5 and `wb_valid` outside states 3 and 4 change nothing and produce no grant.
- R10: A read request to an uncached or shared entry is granted shared in the next cycle and leaves the directory unchanged.
- R11: The load port writes pointers, valid flags and levels only in state 0 or 1 with no request in the same cycle. After a load the state becomes 1 if any loaded flag is set, otherwise 0. In every other case the load is ignored.
- R12: A request of either kind from the current exclusive owner is granted exclusive in the next cycle, and the directory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request strobe |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_node | input | NODE_W | Requesting node |
| ack_valid | input | 1 | Invalidation acknowledgment strobe |
| wb_valid | input | 1 | Writeback arrival strobe |
| dir_ld | input | 1 | Pointer array load strobe |
| dir_ld_ptr | input | NUM_PTRS*NODE_W | Pointers to load, slot i at bits i*NODE_W |
| dir_ld_vld | input | NUM_PTRS | Valid flags to load |
| dir_ld_lvl | input | NUM_PTRS*LVL_W | Tree levels to load |
| inv_valid | output | NUM_PTRS/2 | Per-pair invalidation strobe |
| inv_node | output | NUM_PTRS/2*NODE_W | Per-pair invalidation target |
| relay_valid | output | NUM_PTRS/2 | Target must forward to relay_node |
| relay_node | output | NUM_PTRS/2*NODE_W | Odd root the target invalidates |
| wb_req_valid | output | 1 | Writeback demand to owner |
| wb_req_node | output | NODE_W | Owner asked to write back |
| grant_valid | output | 1 | Grant strobe |
| grant_excl | output | 1 | Grant is exclusive |
| grant_node | output | NODE_W | Node receiving the grant |
| nack_valid | output | 1 | Negative acknowledgment strobe |
| nack_node | output | NODE_W | Node told to retry |
| dir_ptr | output | NUM_PTRS*NODE_W | Current pointers |
| dir_vld | output | NUM_PTRS | Current valid flags |
| dir_lvl | output | NUM_PTRS*LVL_W | Current tree levels |
| dir_state | output | 3 | State code |

## Verification
Two things can happen in the same cycle: the final awaited acknowledgment (or writeback) completes the pending operation, and a new request arrives. The bench provokes this by raising a new read request together with the second of two expected acknowledgments. One cycle later it expects two results at once: the exclusive grant to the original writer, and a negative acknowledgment to the newcomer. It also expects the directory to hold only the writer, so the newcomer must not have been recorded anywhere. A writeback arriving during invalidation and an acknowledgment arriving during a writeback wait are applied the same way, to show that a stray completion strobe never ends the wrong wait.

// File: rtl/dir_seq_pkg.sv
// Shared definitions for the home directory write-miss sequencer.
// Assumes: state codes are visible at the top ports and must stay fixed.
package dir_seq_pkg;

    typedef enum logic [2:0] {
        ST_UNC   = 3'd0,  // no cached copy
        ST_SHR   = 3'd1,  // one or more sharer trees
        ST_EXC   = 3'd2,  // single exclusive owner in slot 0
        ST_RMWW  = 3'd3,  // read miss, waiting for owner writeback
        ST_WMWW  = 3'd4,  // write miss, waiting for owner writeback
        ST_WMINV = 3'd5   // write miss, invalidations outstanding
    } dir_state_e;

    // Reports whether a state is a transient wait state.
    function automatic logic is_transient(input dir_state_e s);
        return (s == ST_RMWW) || (s == ST_WMWW) || (s == ST_WMINV);
    endfunction

endpackage

// File: rtl/dir_ptr_array.sv
// Pointer storage for one directory entry: pointer, valid flag and tree
// level per slot. Three update operations, highest priority first:
// set-owner, set-pair, load. Assumes NUM_PTRS >= 2 and that the caller
// raises at most one operation per cycle.
module dir_ptr_array #(
    parameter int NODE_W   = 4,
    parameter int NUM_PTRS = 4,
    parameter int LVL_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         own_set,
    input  logic [NODE_W-1:0]            own_node,
    input  logic                         pair_set,
    input  logic [NODE_W-1:0]            pair_n0,
    input  logic [NODE_W-1:0]            pair_n1,
    input  logic                         ld,
    input  logic [NUM_PTRS*NODE_W-1:0]   ld_ptr,
    input  logic [NUM_PTRS-1:0]          ld_vld,
    input  logic [NUM_PTRS*LVL_W-1:0]    ld_lvl,
    output logic [NUM_PTRS*NODE_W-1:0]   ptr,
    output logic [NUM_PTRS-1:0]          vld,
    output logic [NUM_PTRS*LVL_W-1:0]    lvl
);

    localparam logic [NUM_PTRS-1:0] VLD_OWN  = NUM_PTRS'(1);
    localparam logic [NUM_PTRS-1:0] VLD_PAIR = NUM_PTRS'(3);

    logic [NUM_PTRS*NODE_W-1:0] ptr_q;
    logic [NUM_PTRS-1:0]        vld_q;
    logic [NUM_PTRS*LVL_W-1:0]  lvl_q;

    // Applies the one requested update to the slot storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            vld_q <= '0;
            lvl_q <= '0;
        end else if (own_set) begin
            ptr_q                 <= '0;
            ptr_q[NODE_W-1:0]     <= own_node;
            vld_q                 <= VLD_OWN;
            lvl_q                 <= '0;
        end else if (pair_set) begin
            ptr_q                 <= '0;
            ptr_q[NODE_W-1:0]     <= pair_n0;
            ptr_q[2*NODE_W-1:NODE_W] <= pair_n1;
            vld_q                 <= VLD_PAIR;
            lvl_q                 <= '0;
        end else if (ld) begin
            ptr_q <= ld_ptr;
            vld_q <= ld_vld;
            lvl_q <= ld_lvl;
        end
    end

    assign ptr = ptr_q;
    assign vld = vld_q;
    assign lvl = lvl_q;

    // R4: a set-owner leaves only slot 0 valid with cleared levels.
    assert_owner_only_slot0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        own_set |=> (vld_q == VLD_OWN) && (lvl_q == '0) && (ptr_q[NODE_W-1:0] == $past(own_node)));

    // R7: a set-pair leaves exactly slots 0 and 1 valid.
    assert_pair_two_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_set && !own_set) |=> (vld_q == VLD_PAIR) && (lvl_q == '0));

endmodule

// File: rtl/dir_inv_planner.sv
// Combinational planner: turns the pointer array into one invalidation
// per slot pair. The even root is the target and relays to the odd
// root; if the even slot is empty the odd root is targeted directly.
// Also counts how many acknowledgments the home must collect.
// Assumes NUM_PTRS is even.
module dir_inv_planner #(
    parameter int NODE_W   = 4,
    parameter int NUM_PTRS = 4,
    parameter int CNT_W    = 2,
    localparam int NPAIR   = NUM_PTRS / 2
) (
    input  logic [NUM_PTRS*NODE_W-1:0] ptr,
    input  logic [NUM_PTRS-1:0]        vld,
    output logic [NPAIR-1:0]           inv_vld,
    output logic [NPAIR*NODE_W-1:0]    inv_node,
    output logic [NPAIR-1:0]           rly_vld,
    output logic [NPAIR*NODE_W-1:0]    rly_node,
    output logic [CNT_W-1:0]           exp_cnt
);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [NODE_W-1:0] even_ptr;
        logic [NODE_W-1:0] odd_ptr;
        assign even_ptr = ptr[(2*p)*NODE_W +: NODE_W];
        assign odd_ptr  = ptr[(2*p+1)*NODE_W +: NODE_W];
        // Picks the pair's target and the relay it must forward.
        assign inv_vld[p]                  = vld[2*p] | vld[2*p+1];
        assign inv_node[p*NODE_W +: NODE_W] = vld[2*p] ? even_ptr : odd_ptr;
        assign rly_vld[p]                  = vld[2*p] & vld[2*p+1];
        assign rly_node[p*NODE_W +: NODE_W] = (vld[2*p] & vld[2*p+1]) ? odd_ptr : '0;
    end

    // Counts pairs that will answer with one acknowledgment each.
    always_comb begin
        exp_cnt = '0;
        for (int p = 0; p < NPAIR; p++) begin
            exp_cnt = exp_cnt + CNT_W'(inv_vld[p]);
        end
    end

endmodule

// File: rtl/dir_ack_counter.sv
// Down-counter of outstanding invalidation acknowledgments.
// Assumes the controller only decrements while a count is loaded.
module dir_ack_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Loads the expected count or retires one acknowledgment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));

    // R3: no acknowledgment is accepted when none is outstanding.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

    // R3: a load for an invalidation round is never zero.
    assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> (ld_val != '0));

endmodule

// File: rtl/dir_home_wm_seq.sv
// Home-side sequencer for one directory entry. Serves write misses by
// invalidating sharer-tree roots pair-wise and granting after all
// expected acknowledgments; serves misses to an exclusive entry through
// a writeback wait; rejects requests while a wait is in progress.
// Assumes at most one request, one acknowledgment and one writeback
// strobe per cycle. All output strobes are registered one-cycle pulses.
module dir_home_wm_seq
    import dir_seq_pkg::*;
#(
    parameter int NODE_W   = 4,
    parameter int NUM_PTRS = 4,
    parameter int LVL_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [NODE_W-1:0]                 req_node,
    input  logic                              ack_valid,
    input  logic                              wb_valid,
    input  logic                              dir_ld,
    input  logic [NUM_PTRS*NODE_W-1:0]        dir_ld_ptr,
    input  logic [NUM_PTRS-1:0]               dir_ld_vld,
    input  logic [NUM_PTRS*LVL_W-1:0]         dir_ld_lvl,
    output logic [NUM_PTRS/2-1:0]             inv_valid,
    output logic [(NUM_PTRS/2)*NODE_W-1:0]    inv_node,
    output logic [NUM_PTRS/2-1:0]             relay_valid,
    output logic [(NUM_PTRS/2)*NODE_W-1:0]    relay_node,
    output logic                              wb_req_valid,
    output logic [NODE_W-1:0]                 wb_req_node,
    output logic                              grant_valid,
    output logic                              grant_excl,
    output logic [NODE_W-1:0]                 grant_node,
    output logic                              nack_valid,
    output logic [NODE_W-1:0]                 nack_node,
    output logic [NUM_PTRS*NODE_W-1:0]        dir_ptr,
    output logic [NUM_PTRS-1:0]               dir_vld,
    output logic [NUM_PTRS*LVL_W-1:0]         dir_lvl,
    output logic [2:0]                        dir_state
);

    localparam int NPAIR = NUM_PTRS / 2;
    localparam int CNT_W = $clog2(NPAIR + 1);

    dir_state_e state_q, state_d;
    logic [NODE_W-1:0] pend_q, pend_d;
    logic [NODE_W-1:0] owner;

    logic own_set, pair_set, ld_acc, cnt_ld, cnt_dec, cnt_last, issue;
    logic [NODE_W-1:0] own_node;
    logic grant_d, gexcl_d, wbr_d, nack_d;
    logic [NODE_W-1:0] gnode_d;

    logic [NPAIR-1:0]        p_inv_vld, p_rly_vld;
    logic [NPAIR*NODE_W-1:0] p_inv_node, p_rly_node;
    logic [CNT_W-1:0]        p_exp_cnt;

    dir_ptr_array #(.NODE_W(NODE_W), .NUM_PTRS(NUM_PTRS), .LVL_W(LVL_W)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_set  (own_set),
        .own_node (own_node),
        .pair_set (pair_set),
        .pair_n0  (owner),
        .pair_n1  (pend_q),
        .ld       (ld_acc),
        .ld_ptr   (dir_ld_ptr),
        .ld_vld   (dir_ld_vld),
        .ld_lvl   (dir_ld_lvl),
        .ptr      (dir_ptr),
        .vld      (dir_vld),
        .lvl      (dir_lvl)
    );

    dir_inv_planner #(.NODE_W(NODE_W), .NUM_PTRS(NUM_PTRS), .CNT_W(CNT_W)) u_plan (
        .ptr      (dir_ptr),
        .vld      (dir_vld),
        .inv_vld  (p_inv_vld),
        .inv_node (p_inv_node),
        .rly_vld  (p_rly_vld),
        .rly_node (p_rly_node),
        .exp_cnt  (p_exp_cnt)
    );

    dir_ack_counter #(.CNT_W(CNT_W)) u_acks (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (cnt_ld),
        .ld_val (p_exp_cnt),
        .dec    (cnt_dec),
        .last   (cnt_last)
    );

    assign owner   = dir_ptr[NODE_W-1:0];
    assign cnt_dec = ack_valid && (state_q == ST_WMINV);

    // Decides the next state, directory update and output pulses.
    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        own_set  = 1'b0;
        own_node = pend_q;
        pair_set = 1'b0;
        ld_acc   = 1'b0;
        cnt_ld   = 1'b0;
        issue    = 1'b0;
        grant_d  = 1'b0;
        gexcl_d  = 1'b0;
        gnode_d  = req_node;
        wbr_d    = 1'b0;
        nack_d   = req_valid && is_transient(state_q);
        case (state_q)
            ST_UNC, ST_SHR: begin
                if (req_valid) begin
                    if (req_write && (|dir_vld)) begin
                        state_d = ST_WMINV;
                        issue   = 1'b1;
                        cnt_ld  = 1'b1;
                        pend_d  = req_node;
                    end else if (req_write) begin
                        grant_d  = 1'b1;
                        gexcl_d  = 1'b1;
                        own_set  = 1'b1;
                        own_node = req_node;
                        state_d  = ST_EXC;
                    end else begin
                        grant_d = 1'b1;
                    end
                end else if (dir_ld) begin
                    ld_acc  = 1'b1;
                    state_d = (|dir_ld_vld) ? ST_SHR : ST_UNC;
                end
            end
            ST_EXC: begin
                if (req_valid) begin
                    if (req_node == owner) begin
                        grant_d = 1'b1;
                        gexcl_d = 1'b1;
                    end else begin
                        wbr_d   = 1'b1;
                        pend_d  = req_node;
                        state_d = req_write ? ST_WMWW : ST_RMWW;
                    end
                end
            end
            ST_RMWW: begin
                if (wb_valid) begin
                    grant_d  = 1'b1;
                    gnode_d  = pend_q;
                    pair_set = 1'b1;
                    state_d  = ST_SHR;
                end
            end
            ST_WMWW: begin
                if (wb_valid) begin
                    grant_d = 1'b1;
                    gexcl_d = 1'b1;
                    gnode_d = pend_q;
                    own_set = 1'b1;
                    state_d = ST_EXC;
                end
            end
            ST_WMINV: begin
                if (ack_valid && cnt_last) begin
                    grant_d = 1'b1;
                    gexcl_d = 1'b1;
                    gnode_d = pend_q;
                    own_set = 1'b1;
                    state_d = ST_EXC;
                end
            end
            default: state_d = ST_UNC;
        endcase
    end

    // Registers state, pending requester and all output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_UNC;
            pend_q       <= '0;
            inv_valid    <= '0;
            inv_node     <= '0;
            relay_valid  <= '0;
            relay_node   <= '0;
            wb_req_valid <= 1'b0;
            wb_req_node  <= '0;
            grant_valid  <= 1'b0;
            grant_excl   <= 1'b0;
            grant_node   <= '0;
            nack_valid   <= 1'b0;
            nack_node    <= '0;
        end else begin
            state_q      <= state_d;
            pend_q       <= pend_d;
            inv_valid    <= issue ? p_inv_vld : '0;
            inv_node     <= issue ? p_inv_node : '0;
            relay_valid  <= issue ? p_rly_vld : '0;
            relay_node   <= issue ? p_rly_node : '0;
            wb_req_valid <= wbr_d;
            wb_req_node  <= owner;
            grant_valid  <= grant_d;
            grant_excl   <= gexcl_d;
            grant_node   <= gnode_d;
            nack_valid   <= nack_d;
            nack_node    <= req_node;
        end
    end

    assign dir_state = state_q;

    // R3: no grant is ever visible while acknowledgments are pending.
    assert_no_grant_while_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WMINV) |-> !grant_valid);

    // R8: every request seen in a wait state is answered with a retry.
    assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_transient(state_q)) |=> (nack_valid && (nack_node == $past(req_node))));

    // R2: invalidations only accompany entry into the invalidating state.
    assert_inv_in_wminv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |-> (state_q == ST_WMINV));

    // R2: a relay is only attached to a pair that sends an invalidation.
    assert_relay_has_root_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((relay_valid & ~inv_valid) == '0));

    // R4: an exclusive grant leaves the grantee alone in slot 0.
    assert_excl_grant_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_excl) |-> ((state_q == ST_EXC) && dir_vld[0] && (owner == grant_node)));

endmodule

// File: tb/dir_home_wm_seq_bench.sv
// Directed bench for the home write-miss sequencer. Inputs change at the
// falling edge; registered outputs are checked at the next falling edge.
module dir_home_wm_seq_bench;

    localparam int NODE_W   = 4;
    localparam int NUM_PTRS = 4;
    localparam int LVL_W    = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, ack_valid, wb_valid, dir_ld;
    logic [3:0]  req_node;
    logic [15:0] dir_ld_ptr, dir_ld_lvl;
    logic [3:0]  dir_ld_vld;
    logic [1:0]  inv_valid, relay_valid;
    logic [7:0]  inv_node, relay_node;
    logic        wb_req_valid, grant_valid, grant_excl, nack_valid;
    logic [3:0]  wb_req_node, grant_node, nack_node;
    logic [15:0] dir_ptr, dir_lvl;
    logic [3:0]  dir_vld;
    logic [2:0]  dir_state;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dir_home_wm_seq #(.NODE_W(NODE_W), .NUM_PTRS(NUM_PTRS), .LVL_W(LVL_W)) u_dir_home_wm_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_node(req_node),
        .ack_valid(ack_valid), .wb_valid(wb_valid),
        .dir_ld(dir_ld), .dir_ld_ptr(dir_ld_ptr), .dir_ld_vld(dir_ld_vld), .dir_ld_lvl(dir_ld_lvl),
        .inv_valid(inv_valid), .inv_node(inv_node),
        .relay_valid(relay_valid), .relay_node(relay_node),
        .wb_req_valid(wb_req_valid), .wb_req_node(wb_req_node),
        .grant_valid(grant_valid), .grant_excl(grant_excl), .grant_node(grant_node),
        .nack_valid(nack_valid), .nack_node(nack_node),
        .dir_ptr(dir_ptr), .dir_vld(dir_vld), .dir_lvl(dir_lvl), .dir_state(dir_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_write = 0; req_node = 0;
        ack_valid = 0; wb_valid = 0; dir_ld = 0;
        dir_ld_ptr = 0; dir_ld_vld = 0; dir_ld_lvl = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
    endtask

    // Drives one request for one cycle and returns at the check point.
    task automatic request(input logic wr, input logic [3:0] node);
        req_valid = 1; req_write = wr; req_node = node;
        tick();
        req_valid = 0; req_write = 0;
    endtask

    task automatic load(input logic [15:0] p, input logic [3:0] v, input logic [15:0] l);
        dir_ld = 1; dir_ld_ptr = p; dir_ld_vld = v; dir_ld_lvl = l;
        tick();
        dir_ld = 0;
    endtask

    task automatic ack_once();
        ack_valid = 1;
        tick();
        ack_valid = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", dir_state, 0);
        check("R1 vld", dir_vld, 0);
        check("R1 strobes", {grant_valid, nack_valid, wb_req_valid, inv_valid}, 0);
    endtask

    task automatic t_stray_in_unc();
        ack_valid = 1; wb_valid = 1;
        tick();
        ack_valid = 0; wb_valid = 0;
        check("R9 stray state", dir_state, 0);
        check("R9 stray grant", grant_valid, 0);
    endtask

    task automatic t_read_uncached();
        request(0, 4'd3);
        check("R10 grant", {grant_valid, grant_excl, grant_node}, {2'b10, 4'd3});
        check("R10 dir", {dir_state, dir_vld}, 0);
    endtask

    task automatic t_write_uncached();
        request(1, 4'd5);
        check("R5 grant", {grant_valid, grant_excl, grant_node}, {2'b11, 4'd5});
        check("R5 no inv", inv_valid, 0);
        check("R4 dir", {dir_state, dir_vld, dir_ptr}, {3'd2, 4'b0001, 16'h0005});
    endtask

    task automatic t_load_in_exc();
        load(16'h1234, 4'hF, 16'h1111);
        check("R11 load ignored in exclusive", {dir_state, dir_vld, dir_ptr, dir_lvl},
              {3'd2, 4'b0001, 16'h0005, 16'h0000});
    endtask

    task automatic t_owner_rerequest();
        request(0, 4'd5);
        check("R12 grant", {grant_valid, grant_excl, grant_node}, {2'b11, 4'd5});
        check("R12 no wb", {wb_req_valid, dir_state}, {1'b0, 3'd2});
    endtask

    task automatic t_write_to_owned();
        request(1, 4'd7);
        check("R6 wb demand", {wb_req_valid, wb_req_node, dir_state}, {1'b1, 4'd5, 3'd4});
        ack_once();
        check("R9 ack in wb wait", {grant_valid, dir_state}, {1'b0, 3'd4});
        request(1, 4'd9);
        check("R8 nack", {nack_valid, nack_node, dir_state}, {1'b1, 4'd9, 3'd4});
        wb_valid = 1;
        tick();
        wb_valid = 0;
        check("R6 grant", {grant_valid, grant_excl, grant_node}, {2'b11, 4'd7});
        check("R4 dir after wb", {dir_state, dir_vld, dir_ptr}, {3'd2, 4'b0001, 16'h0007});
    endtask

    task automatic t_read_to_owned();
        request(0, 4'd10);
        check("R7 wb demand", {wb_req_valid, wb_req_node, dir_state}, {1'b1, 4'd7, 3'd3});
        wb_valid = 1;
        tick();
        wb_valid = 0;
        check("R7 grant", {grant_valid, grant_excl, grant_node}, {2'b10, 4'd10});
        check("R7 dir", {dir_state, dir_vld, dir_ptr, dir_lvl}, {3'd1, 4'b0011, 16'h00A7, 16'h0});
    endtask

    task automatic t_load_and_full_write();
        load(16'h4321, 4'hF, 16'h0312);
        check("R11 load", {dir_state, dir_vld, dir_ptr, dir_lvl}, {3'd1, 4'hF, 16'h4321, 16'h0312});
        dir_ld = 1; dir_ld_ptr = 16'h9999; dir_ld_vld = 4'h1; dir_ld_lvl = 16'h0;
        request(0, 4'd11);
        dir_ld = 0;
        check("R11 load with request ignored", {dir_vld, dir_ptr}, {4'hF, 16'h4321});
        check("R10 shared grant", {grant_valid, grant_excl, grant_node}, {2'b10, 4'd11});
        request(1, 4'd12);
        check("R2 inv", {inv_valid, inv_node}, {2'b11, 8'h31});
        check("R2 relay", {relay_valid, relay_node}, {2'b11, 8'h42});
        check("R2 state", dir_state, 5);
        ack_once();
        check("R3 early", {grant_valid, dir_state}, {1'b0, 3'd5});
        ack_valid = 1; req_valid = 1; req_write = 0; req_node = 4'd13;
        tick();
        ack_valid = 0; req_valid = 0;
        check("R3 grant on last ack", {grant_valid, grant_excl, grant_node}, {2'b11, 4'd12});
        check("R8 nack at completion", {nack_valid, nack_node}, {1'b1, 4'd13});
        check("R4 dir", {dir_state, dir_vld, dir_ptr, dir_lvl}, {3'd2, 4'b0001, 16'h000C, 16'h0});
    endtask

    task automatic t_odd_only_pair();
        do_reset();
        load(16'h0650, 4'b0110, 16'h0110);
        request(1, 4'd14);
        check("R2 odd direct", {inv_valid, inv_node, relay_valid, relay_node}, {2'b11, 8'h65, 2'b00, 8'h00});
        wb_valid = 1;
        tick();
        wb_valid = 0;
        check("R9 wb in inv", {grant_valid, dir_state}, {1'b0, 3'd5});
        ack_once();
        check("R3 one of two", grant_valid, 0);
        ack_once();
        check("R3 grant", {grant_valid, grant_node, dir_state}, {1'b1, 4'd14, 3'd2});
    endtask

    task automatic t_single_tree();
        do_reset();
        load(16'h8000, 4'b1000, 16'h2000);
        request(1, 4'd2);
        check("R2 single pair", {inv_valid, inv_node, relay_valid}, {2'b10, 8'h80, 2'b00});
        ack_once();
        check("R3 single ack grant", {grant_valid, grant_excl, grant_node}, {2'b11, 4'd2});
        check("R4 dir", {dir_vld, dir_ptr, dir_lvl}, {4'b0001, 16'h0002, 16'h0});
        ack_once();
        check("R9 ack in exclusive", {grant_valid, dir_state, dir_ptr}, {1'b0, 3'd2, 16'h0002});
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        t_reset();
        t_stray_in_unc();
        t_read_uncached();
        t_write_uncached();
        t_load_in_exc();
        t_owner_rerequest();
        t_write_to_owned();
        t_read_to_owned();
        t_load_and_full_write();
        t_odd_only_pair();
        t_single_tree();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule